// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Bank

This block is the host-visible register file for a pair of bus-master DMA channels. Each channel owns a command byte, a six-bit software scratch byte, a status byte and a 32-bit descriptor-table pointer. A host reaches them through a word-wide read/write port with per-byte enables. The two DMA engines report progress by pulsing set and clear inputs on the status bits. Each engine gets its command byte as a one-cycle strobe whenever the host writes it.

Two further words serve drivers that poll both channels at once. They fold command, status, the per-channel serial-link interrupt flags and the second channel's DMA interrupt into a single read. Those same two words also accept writes as aliases of each channel's command, scratch and status bytes. Status bits follow mixed rules. Bits 5 and 6 are plain storage. Bits 1 and 2 are cleared by writing a one. Bit 0 belongs to the engine alone. Reads are combinational from the current word address. Any address the map does not name returns zero and ignores writes.

Top module: `dual_bmdma_regbank`

## Requirements
- R1: The address port carries a byte address with its two low bits dropped (`bus_addr` = byte address >> 2). Words 0x00 (channel 0) and 0x08 (channel 1) read as {8'h00, status, 2'b00, scratch[5:0], command}. Byte lane 3 of these words reads zero and ignores writes.
- R2: Words 0x04 (channel 0) and 0x0C (channel 1) hold a 32-bit descriptor pointer. Each byte lane is written only when its enable is set, and the word reads back whole.
- R3: Writes to words 0x10 (channel 0) and 0x18 (channel 1) act exactly like writes to words 0x00 and 0x08. Lane 0 is command, lane 1 is scratch, lane 2 is status.
- R4: A scratch write stores bits [5:0] of its lane; bits [7:6] always read zero.
- R5: A status write loads bits 5 and 6 from the written byte. It clears bit 1 and bit 2 wherever the written bit is one and leaves them alone otherwise. It leaves bit 0 unchanged. Bits 3, 4 and 7 read zero.
- R6: A set pulse from the engine on bit 0 (active), bit 1 (error) or bit 2 (interrupt) forces that bit to one on the next edge, even when a host write clears it in the same cycle. An active-clear pulse zeroes bit 0 unless a set arrives with it.
- R7: Word 0x10 reads {status1, status0, byte1, byte0}. byte0 is command0 with bit 4 ORed with channel 0's serial-link interrupt and bit 6 ORed with channel 1's. byte1 is zero except bit 6, which equals status1 bit 2.
- R8: Word 0x18 reads {8'h00, status1, 8'h00, byte0}, where byte0 is command1 with bit 4 ORed with channel 1's serial-link interrupt.
- R9: Words 0x14, 0x1C and every word at or above 0x20 read zero, and writes to them change no register and raise no strobe.
- R10: A write with lane 0 enabled to a channel's command word raises that channel's `cmd_stb` bit for exactly the following cycle. `cmd_val` carries the written byte in that cycle. The other channel's strobe stays low.
- R11: After a synchronous active-low reset every register, strobe and view reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Host write enable for this cycle |
| bus_addr | input | ADDR_W-2 | Word address (byte address >> 2) |
| bus_be | input | 4 | Byte-lane enables for a write |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| eng_act_set | input | 2 | Per-channel pulse setting status bit 0 |
| eng_act_clr | input | 2 | Per-channel pulse clearing status bit 0 |
| eng_err_set | input | 2 | Per-channel pulse setting status bit 1 |
| eng_irq_set | input | 2 | Per-channel pulse setting status bit 2 |
| sata_irq | input | 2 | Per-channel serial-link interrupt level |
| cmd_stb | output | 2 | Per-channel one-cycle command-write strobe |
| cmd_val | output | 16 | Strobed command bytes, channel 1 in [15:8] |

## Verification
Status writes are swept over every one of the 256 written bytes, against each of the eight prior settings of the engine-owned bits, through both the plain and the alias word. This separates write-one-to-clear, plain storage and the protected active bit. Scratch and command bytes are swept over all 256 values on both channels. This exposes masking errors and crossed strobes. Every byte-enable combination goes to each descriptor pointer. The packed words are read under all four serial-interrupt combinations with distinct per-channel contents, so a swapped channel or a misplaced bit shows. Every word address is written with all ones, and the full decoded state is re-read afterwards to show that unnamed addresses leave it untouched.

// File: rtl/dbm_pkg.sv
// Package: shared constants and types for the dual-channel DMA register bank.
// Assumes exactly two channels; the address map is laid out for that count.
package dbm_pkg;
    localparam int NCH    = 2;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / BYTE_W;
    localparam int SW_W   = 6;

    // Status bit positions
    localparam int ST_ACT   = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_IRQ   = 2;
    localparam int ST_CAP_L = 5;
    localparam int ST_CAP_H = 6;

    // Byte lanes within a channel word
    localparam int LANE_CMD = 0;
    localparam int LANE_SW  = 1;
    localparam int LANE_ST  = 2;

    // Read-source selector produced by the decoder
    typedef enum logic [2:0] {
        RS_NONE,
        RS_CHAN,
        RS_DTAB,
        RS_PACK0,
        RS_PACK1
    } rsel_e;

    // Per-channel write enables produced by the decoder
    typedef struct packed {
        logic            cmd_we;
        logic            sw_we;
        logic            st_we;
        logic [BE_W-1:0] dt_be;
    } chwr_t;
endpackage

// File: rtl/dbm_addr_decode.sv
// Module: address decoder for the register bank.
// Turns a word address, write enable and byte enables into per-channel
// register write enables and a read-source selector. Assumes ADDR_W > 5,
// so that the decoded window (word offsets 0..7) is a strict subset.
module dbm_addr_decode
    import dbm_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:2]  waddr,
    input  logic               we,
    input  logic [BE_W-1:0]    be,
    output chwr_t [NCH-1:0]    wr,
    output rsel_e              rsel,
    output logic               rch
);
    localparam int WIN_LSB = 5;

    logic       in_win;
    logic [2:0] lw;

    assign lw     = waddr[WIN_LSB-1:2];
    assign in_win = (waddr[ADDR_W-1:WIN_LSB] == '0);
    assign rch    = lw[1];

    // Pick the read source for the addressed word
    always_comb begin
        rsel = RS_NONE;
        if (in_win) begin
            case (lw)
                3'd0, 3'd2: rsel = RS_CHAN;
                3'd1, 3'd3: rsel = RS_DTAB;
                3'd4:       rsel = RS_PACK0;
                3'd6:       rsel = RS_PACK1;
                default:    rsel = RS_NONE;
            endcase
        end
    end

    // Per-channel write enables; bit 1 of the word offset selects the channel
    for (genvar ch = 0; ch < NCH; ch++) begin : g_wr
        logic hit_ch;
        logic std_hit;
        logic dt_hit;

        assign hit_ch  = in_win && we && (lw[1] == 1'(ch));
        assign std_hit = !lw[0];
        assign dt_hit  = lw[0] && !lw[2];

        assign wr[ch].cmd_we = hit_ch && std_hit && be[LANE_CMD];
        assign wr[ch].sw_we  = hit_ch && std_hit && be[LANE_SW];
        assign wr[ch].st_we  = hit_ch && std_hit && be[LANE_ST];
        assign wr[ch].dt_be  = (hit_ch && dt_hit) ? be : '0;
    end
endmodule

// File: rtl/dbm_chan_regs.sv
// Module: register set of one DMA channel.
// Holds command, scratch, status and descriptor pointer, and emits a
// registered one-cycle command strobe. Engine set pulses win over host
// write-one-to-clear; status bit 0 is never touched by host writes.
module dbm_chan_regs
    import dbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chwr_t             wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              act_set,
    input  logic              act_clr,
    input  logic              err_set,
    input  logic              irq_set,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [SW_W-1:0]   sw_q,
    output logic [BYTE_W-1:0] st_q,
    output logic [WORD_W-1:0] dt_q,
    output logic              stb_q,
    output logic [BYTE_W-1:0] stb_val
);
    localparam int ST_LSB = LANE_ST * BYTE_W;
    localparam int SW_LSB = LANE_SW * BYTE_W;

    logic       act_q;
    logic       err_q;
    logic       irq_q;
    logic [1:0] cap_q;

    // Command byte storage
    always_ff @(posedge clk) begin
        if (!rst_n)         cmd_q <= '0;
        else if (wr.cmd_we) cmd_q <= wdata[BYTE_W-1:0];
    end

    // Scratch byte storage, upper lane bits discarded
    always_ff @(posedge clk) begin
        if (!rst_n)        sw_q <= '0;
        else if (wr.sw_we) sw_q <= wdata[SW_LSB +: SW_W];
    end

    // Active bit: engine-owned, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       act_q <= 1'b0;
        else if (act_set) act_q <= 1'b1;
        else if (act_clr) act_q <= 1'b0;
    end

    // Error and interrupt bits: engine set wins over host write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            err_q <= err_set | (err_q & ~(wr.st_we & wdata[ST_LSB + ST_ERR]));
            irq_q <= irq_set | (irq_q & ~(wr.st_we & wdata[ST_LSB + ST_IRQ]));
        end
    end

    // Capability bits: plain read/write storage
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_q <= '0;
        else if (wr.st_we) cap_q <= wdata[ST_LSB + ST_CAP_H : ST_LSB + ST_CAP_L];
    end

    // Descriptor pointer, one byte lane per enable
    for (genvar b = 0; b < BE_W; b++) begin : g_dt
        always_ff @(posedge clk) begin
            if (!rst_n)          dt_q[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr.dt_be[b]) dt_q[b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
        end
    end

    // One-cycle command strobe toward the DMA engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q   <= 1'b0;
            stb_val <= '0;
        end else begin
            stb_q   <= wr.cmd_we;
            stb_val <= wr.cmd_we ? wdata[BYTE_W-1:0] : '0;
        end
    end

    assign st_q = {1'b0, cap_q, 2'b00, irq_q, err_q, act_q};
endmodule

// File: rtl/dbm_read_mux.sv
// Module: read-data multiplexer for the register bank.
// Builds the per-channel words, the pointer words and the two packed
// views purely combinationally from the channel registers.
module dbm_read_mux
    import dbm_pkg::*;
(
    input  rsel_e                        rsel,
    input  logic                         rch,
    input  logic [NCH-1:0][BYTE_W-1:0]   cmd,
    input  logic [NCH-1:0][SW_W-1:0]     sw,
    input  logic [NCH-1:0][BYTE_W-1:0]   st,
    input  logic [NCH-1:0][WORD_W-1:0]   dt,
    input  logic [NCH-1:0]               sata,
    output logic [WORD_W-1:0]            rdata
);
    // Assemble the selected read word
    always_comb begin
        rdata = '0;
        case (rsel)
            RS_CHAN:  rdata = {8'h00, st[rch], 2'b00, sw[rch], cmd[rch]};
            RS_DTAB:  rdata = dt[rch];
            RS_PACK0: begin
                rdata     = {st[1], st[0], 8'h00, cmd[0]};
                rdata[4]  = cmd[0][4] | sata[0];
                rdata[6]  = cmd[0][6] | sata[1];
                rdata[14] = st[1][ST_IRQ];
            end
            RS_PACK1: begin
                rdata    = {8'h00, st[1], 8'h00, cmd[1]};
                rdata[4] = cmd[1][4] | sata[1];
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dual_bmdma_regbank.sv
// Module: top of the dual-channel bus-master DMA register bank.
// Host side: word address, byte enables, combinational read data.
// Engine side: per-channel status set/clear pulses, serial-link interrupt
// levels in, command strobes out. Synchronous active-low reset.
module dual_bmdma_regbank
    import dbm_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:2]     bus_addr,
    input  logic [3:0]            bus_be,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [1:0]            eng_act_set,
    input  logic [1:0]            eng_act_clr,
    input  logic [1:0]            eng_err_set,
    input  logic [1:0]            eng_irq_set,
    input  logic [1:0]            sata_irq,
    output logic [1:0]            cmd_stb,
    output logic [15:0]           cmd_val
);
    chwr_t [NCH-1:0]               wr;
    rsel_e                         rsel;
    logic                          rch;
    logic [NCH-1:0][BYTE_W-1:0]    cmd_q;
    logic [NCH-1:0][SW_W-1:0]      sw_q;
    logic [NCH-1:0][BYTE_W-1:0]    st_q;
    logic [NCH-1:0][WORD_W-1:0]    dt_q;
    logic [NCH*BYTE_W-1:0]         st_flat;

    dbm_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .waddr (bus_addr),
        .we    (bus_we),
        .be    (bus_be),
        .wr    (wr),
        .rsel  (rsel),
        .rch   (rch)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dbm_chan_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr[ch]),
            .wdata   (bus_wdata),
            .act_set (eng_act_set[ch]),
            .act_clr (eng_act_clr[ch]),
            .err_set (eng_err_set[ch]),
            .irq_set (eng_irq_set[ch]),
            .cmd_q   (cmd_q[ch]),
            .sw_q    (sw_q[ch]),
            .st_q    (st_q[ch]),
            .dt_q    (dt_q[ch]),
            .stb_q   (cmd_stb[ch]),
            .stb_val (cmd_val[ch*BYTE_W +: BYTE_W])
        );
        assign st_flat[ch*BYTE_W +: BYTE_W] = st_q[ch];
    end

    dbm_read_mux u_mux (
        .rsel  (rsel),
        .rch   (rch),
        .cmd   (cmd_q),
        .sw    (sw_q),
        .st    (st_q),
        .dt    (dt_q),
        .sata  (sata_irq),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/dbm_regbank_chk.sv
// Module: assertion checker for dual_bmdma_regbank, attached by bind.
// Observes host port, engine pulses, strobes and the status registers.
module dbm_regbank_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:2] bus_addr,
    input logic [3:0]        bus_be,
    input logic [7:0]        wd_lane0,
    input logic [31:0]       bus_rdata,
    input logic              act_set0,
    input logic              act_clr0,
    input logic              err_set1,
    input logic              irq_set0,
    input logic [1:0]        cmd_stb,
    input logic [15:0]       cmd_val,
    input logic [15:0]       st_flat
);
    logic       in_win;
    logic [2:0] lw;
    logic       cmd0_wr;
    logic       cmd1_wr;
    logic       st0_wr;

    // Local view of the address window
    assign lw      = bus_addr[4:2];
    assign in_win  = (bus_addr[ADDR_W-1:5] == '0);
    assign cmd0_wr = bus_we && bus_be[0] && in_win && (lw == 3'd0 || lw == 3'd4);
    assign cmd1_wr = bus_we && bus_be[0] && in_win && (lw == 3'd2 || lw == 3'd6);
    assign st0_wr  = bus_we && bus_be[2] && in_win && (lw == 3'd0 || lw == 3'd4);

    AST_CMD0_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd0_wr |=> cmd_stb[0] && cmd_val[7:0] == $past(wd_lane0)); // R10
    AST_CMD1_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd1_wr |=> cmd_stb[1] && cmd_val[15:8] == $past(wd_lane0)); // R10
    AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb[0] |-> $past(cmd0_wr)); // R10
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set0 |=> st_flat[2]); // R6
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        err_set1 |=> st_flat[9]); // R6
    AST_ACT_KEPT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st0_wr && !act_set0 && !act_clr0) |=> st_flat[0] == $past(st_flat[0])); // R5
    AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_win || lw == 3'd5 || lw == 3'd7) |-> bus_rdata == 32'h0); // R9
    AST_CHAN_WORD_GAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && (lw == 3'd0 || lw == 3'd2)) |-> bus_rdata[31:24] == 8'h00 && bus_rdata[15:14] == 2'b00); // R4
    AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        st_flat[4:3] == 2'b00 && st_flat[7] == 1'b0 && st_flat[12:11] == 2'b00 && st_flat[15] == 1'b0); // R5
endmodule

bind dual_bmdma_regbank dbm_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .wd_lane0  (bus_wdata[7:0]),
    .bus_rdata (bus_rdata),
    .act_set0  (eng_act_set[0]),
    .act_clr0  (eng_act_clr[0]),
    .err_set1  (eng_err_set[1]),
    .irq_set0  (eng_irq_set[0]),
    .cmd_stb   (cmd_stb),
    .cmd_val   (cmd_val),
    .st_flat   (st_flat)
);

// File: tb/test_dual_bmdma_regbank.sv
// Bench: near-exhaustive sweeps with an arithmetic register model.
module test_dual_bmdma_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;
    localparam int NWORDS = 1 << (AW - 2);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [AW-1:2] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  eng_act_set = '0, eng_act_clr = '0, eng_err_set = '0, eng_irq_set = '0;
    logic [1:0]  sata_irq = '0;
    logic [1:0]  cmd_stb;
    logic [15:0] cmd_val;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [7:0]  m_cmd [2];
    logic [7:0]  m_sw  [2];
    logic [7:0]  m_st  [2];
    logic [31:0] m_dt  [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bmdma_regbank #(.ADDR_W(AW)) i_dual_bmdma_regbank (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_act_set(eng_act_set), .eng_act_clr(eng_act_clr),
        .eng_err_set(eng_err_set), .eng_irq_set(eng_irq_set),
        .sata_irq(sata_irq), .cmd_stb(cmd_stb), .cmd_val(cmd_val)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected read value of a word address from the model
    function automatic logic [31:0] exp_word(input int w);
        logic [31:0] r;
        r = 32'h0;
        if (w < 8) begin
            case (w)
                0: r = {8'h00, m_st[0], m_sw[0], m_cmd[0]};
                2: r = {8'h00, m_st[1], m_sw[1], m_cmd[1]};
                1: r = m_dt[0];
                3: r = m_dt[1];
                4: begin
                    r = {m_st[1], m_st[0], 8'h00, m_cmd[0]};
                    r[4]  = m_cmd[0][4] | sata_irq[0];
                    r[6]  = m_cmd[0][6] | sata_irq[1];
                    r[14] = m_st[1][2];
                end
                6: begin
                    r = {8'h00, m_st[1], 8'h00, m_cmd[1]};
                    r[4] = m_cmd[1][4] | sata_irq[1];
                end
                default: r = 32'h0;
            endcase
        end
        return r;
    endfunction

    // Model effect of a host write
    function automatic void model_write(input int w, input logic [31:0] d, input logic [3:0] be);
        int ch;
        logic [7:0] s;
        if (w >= 8 || w == 5 || w == 7) return;
        ch = (w >> 1) & 1;
        if (w == 1 || w == 3) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) m_dt[ch][b*8 +: 8] = d[b*8 +: 8];
            return;
        end
        if (be[0]) m_cmd[ch] = d[7:0];
        if (be[1]) m_sw[ch] = d[15:8] & 8'h3f;
        if (be[2]) begin
            s = d[23:16];
            m_st[ch] = (s & 8'h60) | (m_st[ch] & 8'h01) | (m_st[ch] & ~s & 8'h06);
        end
    endfunction

    task automatic bwrite(input int w, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = w[AW-3:0]; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
        model_write(w, d, be);
    endtask

    task automatic rchk(input int w, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = w[AW-3:0];
        #1;
        e = exp_word(w);
        chk(bus_rdata === e, tag, bus_rdata, e);
    endtask

    task automatic engine(input int ch, input logic [2:0] setb, input bit clr);
        @(negedge clk);
        eng_act_set[ch] = setb[0]; eng_err_set[ch] = setb[1];
        eng_irq_set[ch] = setb[2]; eng_act_clr[ch] = clr;
        @(negedge clk);
        eng_act_set = '0; eng_err_set = '0; eng_irq_set = '0; eng_act_clr = '0;
        if (setb[0]) m_st[ch][0] = 1'b1; else if (clr) m_st[ch][0] = 1'b0;
        m_st[ch] = m_st[ch] | {5'b0, setb[2:1], 1'b0};
    endtask

    task automatic check_all(input string tag);
        for (int w = 0; w < 8; w++) rchk(w, tag);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_cmd[c] = 0; m_sw[c] = 0; m_st[c] = 0; m_dt[c] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state of every word and strobes
        for (int w = 0; w < NWORDS; w++) rchk(w, "R11 reset read");
        chk(cmd_stb === 2'b00 && cmd_val === 16'h0, "R11 reset strobe", {14'b0, cmd_stb, cmd_val}, 32'h0);

        // R4 R1: scratch sweep on both channels via plain and alias words
        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 256; v++) begin
                bwrite((v & 1) ? 4 + 2*c : 2*c, 32'(v) << 8, 4'b0010);
                rchk(2*c, "R4 scratch mask");
            end

        // R10 R3: command sweep, strobe timing and value, channel isolation
        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 256; v++) begin
                bwrite((v & 1) ? 4 + 2*c : 2*c, 32'(v), 4'b0001);
                chk(cmd_stb === (2'b01 << c), "R10 strobe bit", {30'b0, cmd_stb}, {30'b0, 2'b01 << c});
                chk(cmd_val[c*8 +: 8] === 8'(v), "R10 strobe value", {24'b0, cmd_val[c*8 +: 8]}, v);
                rchk(2*c, "R3 command via alias");
                chk(cmd_stb === 2'b00, "R10 strobe one cycle", {30'b0, cmd_stb}, 0);
            end

        // R5 R6 R3: status write over every byte and prior engine state
        for (int c = 0; c < 2; c++)
            for (int old = 0; old < 8; old++)
                for (int v = 0; v < 256; v++) begin
                    bwrite(2*c, 32'h0006_0000, 4'b0100);
                    engine(c, 3'(old), 1'b1);
                    bwrite((v & 1) ? 4 + 2*c : 2*c, 32'(v) << 16, 4'b0100);
                    rchk(2*c, "R5 status write");
                end

        // R6: engine set beats host clear in the same cycle
        bwrite(0, 32'h0006_0000, 4'b0100);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 0; bus_be = 4'b0100; bus_wdata = 32'h0007_0000;
        eng_err_set[0] = 1'b1; eng_irq_set[0] = 1'b1; eng_act_set[0] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0; eng_err_set = '0; eng_irq_set = '0; eng_act_set = '0;
        m_st[0] = 8'h07;
        rchk(0, "R6 set beats clear");
        engine(0, 3'b000, 1'b1);
        rchk(0, "R6 active clear");
        engine(1, 3'b001, 1'b1);
        rchk(2, "R6 active set beats clear");

        // R2: every byte-enable pattern on both pointers
        for (int c = 0; c < 2; c++)
            for (int be = 0; be < 16; be++) begin
                bwrite(1 + 2*c, {4{8'(8'h10*be + c)}}, 4'(be));
                rchk(1 + 2*c, "R2 pointer lanes");
            end

        // R1: byte lane 3 of channel words ignored and reads zero
        bwrite(0, 32'hFF00_0000, 4'b1000);
        rchk(0, "R1 lane3 ignored");
        bwrite(2, 32'hFFFF_FFFF, 4'b1000);
        rchk(2, "R1 lane3 ignored ch1");

        // R7 R8: packed views under all serial-interrupt combinations
        bwrite(0, 32'h0044_3FAA, 4'b0111);
        bwrite(2, 32'h0060_1555, 4'b0111);
        engine(1, 3'b100, 1'b0);
        engine(0, 3'b010, 1'b0);
        for (int s = 0; s < 4; s++) begin
            sata_irq = 2'(s);
            rchk(4, "R7 packed view 0");
            rchk(6, "R8 packed view 1");
        end
        bwrite(0, 32'h0000_0000, 4'b0001);
        bwrite(2, 32'h0004_0000, 4'b0100);
        for (int s = 0; s < 4; s++) begin
            sata_irq = 2'(s);
            rchk(4, "R7 packed view 0 cleared");
            rchk(6, "R8 packed view 1 cleared");
        end
        sata_irq = 2'b00;

        // R9: writes to undecoded words change nothing and raise no strobe
        for (int w = 0; w < NWORDS; w++)
            if (w >= 8 || w == 5 || w == 7) begin
                bwrite(w, 32'hFFFF_FFFF, 4'b1111);
                chk(cmd_stb === 2'b00, "R9 no strobe", {30'b0, cmd_stb}, 0);
                rchk(w, "R9 undecoded reads zero");
            end
        check_all("R9 state unchanged");

        // R11: reset mid-run clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 2; c++) begin
            m_cmd[c] = 0; m_sw[c] = 0; m_st[c] = 0; m_dt[c] = 0;
        end
        check_all("R11 reset after use");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule